// File: doc/BRIEF.md
# Write-Through-Shared Snooping Cache Line Controller

This block runs one direct-mapped cache on a snooping bus that keeps copies coherent by pushing new words to every holder rather than by removing copies. A line that only this cache holds is written locally and becomes dirty. A line that other caches also hold is written through: the word goes onto the bus, so memory and every other holder take it in the same transfer. A wired shared line on the bus answers one question during each transfer: does any other cache hold this block? That answer decides whether a fill or a write leaves the line exclusive or shared.

Each line is exactly one word. The address splits into an index (the low `IDX_W` bits) and a tag (the remaining bits). A resident line is always valid and sits in one of three states: `LS_VEXCL` (only here, clean), `LS_DIRTY` (only here, modified) or `LS_SHARED` (also held elsewhere, clean). Lines are never invalidated. The only non-resident condition is an empty slot, which exists from reset until the first fill. The request sequencer has five states: `F_IDLE`, `F_WBACK` (write back a dirty victim), `F_PROBE` (bus read), `F_UPDATE` (bus write-through) and `F_DONE` (answer the processor). Snoops are answered in the same cycle they are presented, and any line change they cause is applied at the closing clock edge.

Bus command encoding: 0 = read, 1 = write-through update, 2 = flush (write-back of a whole line). During a read, the driven bus data is 0.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset, every slot is empty. `cpu_ready` is 1 and `bus_valid` is 0, and the first access to any index is a miss.
- R2: A read miss (`F_IDLE`→`F_PROBE`→`F_DONE`) drives one bus read (cmd 0) at the request address in the cycle after acceptance. It fills the line with `bus_rdata` as `LS_SHARED` if `bus_shared_in` is 1, otherwise as `LS_VEXCL`. `cpu_done` pulses one cycle later and carries the filled word.
- R3: A read hit (`F_IDLE`→`F_DONE`) causes no bus traffic. It raises `cpu_done` with the stored word one cycle after acceptance.
- R4: A write hit in `LS_VEXCL` or `LS_DIRTY` causes no bus traffic. It stores the word, leaves the line `LS_DIRTY` and raises `cpu_done` one cycle after acceptance.
- R5: A write hit in `LS_SHARED` (`F_IDLE`→`F_UPDATE`→`F_DONE`) drives a bus update (cmd 1) with the address and word in the cycle after acceptance. The line stays `LS_SHARED` if `bus_shared_in` is 1 in that cycle, otherwise it becomes `LS_VEXCL`.
- R6: A write miss first drives a bus read. If `bus_shared_in` is 1 in that cycle, the next cycle drives a bus update with the word and the line ends `LS_SHARED`. If it is 0, no update is driven and the line is allocated `LS_DIRTY` with the word.
- R7: A miss whose victim is `LS_DIRTY` first drives a flush (cmd 2, `F_WBACK`) carrying the victim's own address and word, and then continues as R2 or R6. A clean victim is replaced with no flush.
- R8: `snp_shared` is 1 in the same cycle as a valid snooped read or update that hits a resident line here, and 0 on a snoop miss and on a snooped flush.
- R9: A snooped read that hits `LS_DIRTY` raises `snp_supply` with the line's word on `snp_flush_data`, which memory also takes. The line then becomes `LS_SHARED`. A snooped read that hits `LS_VEXCL` also moves the line to `LS_SHARED`, without supply.
- R10: A snooped update that hits replaces the local word with `snp_data` and leaves the line `LS_SHARED`.
- R11: While `snp_valid` is 1 or a request is in progress, `cpu_ready` is 0 and `cpu_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits are the index |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Idle and no snoop this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line word during `cpu_done` |
| bus_valid | output | 1 | This cache drives a bus transfer |
| bus_cmd | output | 2 | 0 read, 1 update, 2 flush |
| bus_addr | output | ADDR_W | Transfer address |
| bus_data | output | DATA_W | Update or flush word, 0 on read |
| bus_shared_in | input | 1 | Wired shared line from the other caches |
| bus_rdata | input | DATA_W | Fill word returned for a bus read |
| snp_valid | input | 1 | Another cache's transfer is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache drives the shared line |
| snp_supply | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DATA_W | Supplied word |

## Verification
Results fall due at fixed distances from the accepting edge. A hit completes in the first cycle after it. A bus update or read appears in that first cycle and completion follows one cycle later. A dirty victim pushes everything back by one cycle, and a shared write miss adds one more cycle for the update. Snoop answers are combinational in the cycle the snoop is presented. The bench builds, for each request, the expected sequence of per-cycle bus and completion values from its own line model. It compares that sequence against the outputs at every falling edge, and it samples snoop answers just after driving them and before the closing edge. Line states that the ports cannot show directly are revealed by the bus traffic of a later write hit.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;
    typedef enum logic [1:0] {
        LS_VEXCL  = 2'd0,
        LS_DIRTY  = 2'd1,
        LS_SHARED = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_READ   = 2'd0,
        BC_UPDATE = 2'd1,
        BC_FLUSH  = 2'd2
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_WBACK,
        F_PROBE,
        F_UPDATE,
        F_DONE
    } fsm_e;
endpackage

// File: rtl/wt_line_store.sv
module wt_line_store
    import wt_snoop_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  p_idx,
    output logic              p_present,
    output logic [TAG_W-1:0]  p_tag,
    output line_st_e          p_st,
    output logic [DATA_W-1:0] p_data,
    input  logic [IDX_W-1:0]  s_idx,
    output logic              s_present,
    output logic [TAG_W-1:0]  s_tag,
    output line_st_e          s_st,
    output logic [DATA_W-1:0] s_data,
    input  logic              own_we,
    input  logic [TAG_W-1:0]  own_tag,
    input  line_st_e          own_st,
    input  logic [DATA_W-1:0] own_data,
    input  logic              snp_we,
    input  logic              snp_data_we,
    input  line_st_e          snp_st,
    input  logic [DATA_W-1:0] snp_wdata
);
    localparam int LINES = 1 << IDX_W;

    logic              present_q [LINES];
    logic [TAG_W-1:0]  tag_q     [LINES];
    line_st_e          st_q      [LINES];
    logic [DATA_W-1:0] data_q    [LINES];

    // Own writes win over a snoop landing on the same slot in the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                present_q[i] <= 1'b0;
                tag_q[i]     <= '0;
                st_q[i]      <= LS_VEXCL;
                data_q[i]    <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (own_we && p_idx == IDX_W'(i)) begin
                    present_q[i] <= 1'b1;
                    tag_q[i]     <= own_tag;
                    st_q[i]      <= own_st;
                    data_q[i]    <= own_data;
                end else if (snp_we && s_idx == IDX_W'(i)) begin
                    st_q[i] <= snp_st;
                    if (snp_data_we) begin
                        data_q[i] <= snp_wdata;
                    end
                end
            end
        end
    end

    assign p_present = present_q[p_idx];
    assign p_tag     = tag_q[p_idx];
    assign p_st      = st_q[p_idx];
    assign p_data    = data_q[p_idx];
    assign s_present = present_q[s_idx];
    assign s_tag     = tag_q[s_idx];
    assign s_st      = st_q[s_idx];
    assign s_data    = data_q[s_idx];
endmodule

// File: rtl/wt_snoop_resp.sv
module wt_snoop_resp
    import wt_snoop_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              s_present,
    input  logic [TAG_W-1:0]  s_tag,
    input  line_st_e          s_st,
    input  logic [DATA_W-1:0] s_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_flush_data,
    output logic              snp_we,
    output logic              snp_data_we,
    output line_st_e          snp_st,
    output logic [DATA_W-1:0] snp_wdata
);
    logic hit;

    always_comb begin
        hit            = snp_valid && s_present && (s_tag == snp_tag);
        snp_shared     = hit && (snp_cmd == BC_READ || snp_cmd == BC_UPDATE);
        snp_supply     = snp_shared && (snp_cmd == BC_READ) && (s_st == LS_DIRTY);
        snp_flush_data = snp_supply ? s_data : '0;
        snp_we         = snp_shared;
        snp_data_we    = snp_shared && (snp_cmd == BC_UPDATE);
        snp_st         = LS_SHARED;
        snp_wdata      = snp_data;
    end
endmodule

// File: rtl/wt_req_fsm.sv
module wt_req_fsm
    import wt_snoop_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    input  logic                    snp_valid,
    output logic                    bus_valid,
    output logic [1:0]              bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_data,
    input  logic                    bus_shared_in,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic [IDX_W-1:0]        p_idx,
    input  logic                    p_present,
    input  logic [ADDR_W-IDX_W-1:0] p_tag,
    input  line_st_e                p_st,
    input  logic [DATA_W-1:0]       p_data,
    output logic                    own_we,
    output logic [ADDR_W-IDX_W-1:0] own_tag,
    output line_st_e                own_st,
    output logic [DATA_W-1:0]       own_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    fsm_e              state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic              accept, hit;

    assign cur_addr  = (state_q == F_IDLE) ? cpu_addr : addr_q;
    assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
    assign p_idx     = cur_addr[IDX_W-1:0];
    assign cpu_ready = (state_q == F_IDLE) && !snp_valid;
    assign accept    = cpu_ready && cpu_req;
    assign hit       = p_present && (p_tag == cur_tag);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: begin
                if (accept) begin
                    if (hit) begin
                        state_d = (cpu_we && p_st == LS_SHARED) ? F_UPDATE : F_DONE;
                    end else begin
                        state_d = (p_present && p_st == LS_DIRTY) ? F_WBACK : F_PROBE;
                    end
                end
            end
            F_WBACK:  state_d = F_PROBE;
            F_PROBE:  state_d = (we_q && bus_shared_in) ? F_UPDATE : F_DONE;
            F_UPDATE: state_d = F_DONE;
            F_DONE:   state_d = F_IDLE;
            default:  state_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                we_q    <= cpu_we;
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
        end
    end

    always_comb begin
        bus_valid = 1'b0;
        bus_cmd   = BC_READ;
        bus_addr  = addr_q;
        bus_data  = '0;
        cpu_done  = 1'b0;
        cpu_rdata = '0;
        own_we    = 1'b0;
        own_tag   = cur_tag;
        own_st    = LS_DIRTY;
        own_data  = wdata_q;
        unique case (state_q)
            F_IDLE: begin
                if (accept && hit && cpu_we && p_st != LS_SHARED) begin
                    own_we   = 1'b1;
                    own_data = cpu_wdata;
                end
            end
            F_WBACK: begin
                bus_valid = 1'b1;
                bus_cmd   = BC_FLUSH;
                bus_addr  = {p_tag, addr_q[IDX_W-1:0]};
                bus_data  = p_data;
            end
            F_PROBE: begin
                bus_valid = 1'b1;
                bus_cmd   = BC_READ;
                if (!we_q) begin
                    own_we   = 1'b1;
                    own_st   = bus_shared_in ? LS_SHARED : LS_VEXCL;
                    own_data = bus_rdata;
                end else if (!bus_shared_in) begin
                    own_we = 1'b1;
                end
            end
            F_UPDATE: begin
                bus_valid = 1'b1;
                bus_cmd   = BC_UPDATE;
                bus_data  = wdata_q;
                own_we    = 1'b1;
                own_st    = bus_shared_in ? LS_SHARED : LS_VEXCL;
            end
            F_DONE: begin
                cpu_done  = 1'b1;
                cpu_rdata = p_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
    import wt_snoop_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_flush_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  p_idx;
    logic              p_present, s_present;
    logic [TAG_W-1:0]  p_tag, s_tag, own_tag;
    line_st_e          p_st, s_st, own_st, snp_st;
    logic [DATA_W-1:0] p_data, s_data, own_data, snp_wdata;
    logic              own_we, snp_we, snp_data_we;

    wt_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .p_idx      (p_idx),
        .p_present  (p_present),
        .p_tag      (p_tag),
        .p_st       (p_st),
        .p_data     (p_data),
        .s_idx      (snp_addr[IDX_W-1:0]),
        .s_present  (s_present),
        .s_tag      (s_tag),
        .s_st       (s_st),
        .s_data     (s_data),
        .own_we     (own_we),
        .own_tag    (own_tag),
        .own_st     (own_st),
        .own_data   (own_data),
        .snp_we     (snp_we),
        .snp_data_we(snp_data_we),
        .snp_st     (snp_st),
        .snp_wdata  (snp_wdata)
    );

    wt_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_snoop (
        .snp_valid     (snp_valid),
        .snp_cmd       (snp_cmd),
        .snp_tag       (snp_addr[ADDR_W-1:IDX_W]),
        .snp_data      (snp_data),
        .s_present     (s_present),
        .s_tag         (s_tag),
        .s_st          (s_st),
        .s_data        (s_data),
        .snp_shared    (snp_shared),
        .snp_supply    (snp_supply),
        .snp_flush_data(snp_flush_data),
        .snp_we        (snp_we),
        .snp_data_we   (snp_data_we),
        .snp_st        (snp_st),
        .snp_wdata     (snp_wdata)
    );

    wt_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_ready    (cpu_ready),
        .cpu_done     (cpu_done),
        .cpu_rdata    (cpu_rdata),
        .snp_valid    (snp_valid),
        .bus_valid    (bus_valid),
        .bus_cmd      (bus_cmd),
        .bus_addr     (bus_addr),
        .bus_data     (bus_data),
        .bus_shared_in(bus_shared_in),
        .bus_rdata    (bus_rdata),
        .p_idx        (p_idx),
        .p_present    (p_present),
        .p_tag        (p_tag),
        .p_st         (p_st),
        .p_data       (p_data),
        .own_we       (own_we),
        .own_tag      (own_tag),
        .own_st       (own_st),
        .own_data     (own_data)
    );
endmodule

// File: rtl/wt_snoop_chk.sv
module wt_snoop_chk #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              bus_valid,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic              snp_shared,
    input logic              snp_supply
);
    // R9
    supply_needs_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_shared);

    // R8
    shared_only_on_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> snp_valid);

    // R3
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R7
    flush_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'd2) |=>
            (bus_valid && bus_cmd == 2'd0 && bus_addr[IDX_W-1:0] == $past(bus_addr[IDX_W-1:0])));

    // R5
    update_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == 2'd1) |=> cpu_done);

    // R11
    ready_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (!bus_valid && !cpu_done && !snp_valid));
endmodule

bind wt_snoop_ctrl wt_snoop_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_wt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_done  (cpu_done),
    .bus_valid (bus_valid),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .snp_valid (snp_valid),
    .snp_shared(snp_shared),
    .snp_supply(snp_supply)
);

// File: tb/test_wt_snoop_ctrl.sv
module test_wt_snoop_ctrl;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int DW = 16;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_valid;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          bus_shared_in = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared, snp_supply;
    logic [DW-1:0] snp_flush_data;

    always #5 clk = ~clk;

    wt_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) i_wt_snoop_ctrl (.*);

    int checks = 0;
    int errors = 0;

    // Line model: st 0 = exclusive clean, 1 = dirty, 2 = shared
    int m_present [NL];
    int m_tag     [NL];
    int m_st      [NL];
    int m_data    [NL];

    int q_valid[$], q_cmd[$], q_addr[$], q_data[$], q_done[$];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int v, input int c, input int a, input int d, input int dn);
        q_valid.push_back(v); q_cmd.push_back(c); q_addr.push_back(a);
        q_data.push_back(d);  q_done.push_back(dn);
    endtask

    task automatic cpu_op(input string req, input bit we, input int addr, input int wdata,
                          input bit sh, input int rd);
        int idx = addr % NL;
        int tag = addr / NL;
        bit hit = (m_present[idx] != 0) && (m_tag[idx] == tag);
        q_valid.delete(); q_cmd.delete(); q_addr.delete(); q_data.delete(); q_done.delete();
        if (hit) begin
            if (!we) begin
                push(0, 0, 0, 0, 1);
            end else if (m_st[idx] != 2) begin
                push(0, 0, 0, 0, 1);
                m_st[idx] = 1; m_data[idx] = wdata;
            end else begin
                push(1, 1, addr, wdata, 0);
                push(0, 0, 0, 0, 1);
                m_st[idx] = sh ? 2 : 0; m_data[idx] = wdata;
            end
        end else begin
            if (m_present[idx] != 0 && m_st[idx] == 1)
                push(1, 2, m_tag[idx] * NL + idx, m_data[idx], 0);
            push(1, 0, addr, 0, 0);
            m_present[idx] = 1; m_tag[idx] = tag;
            if (!we) begin
                push(0, 0, 0, 0, 1);
                m_st[idx] = sh ? 2 : 0; m_data[idx] = rd;
            end else if (sh) begin
                push(1, 1, addr, wdata, 0);
                push(0, 0, 0, 0, 1);
                m_st[idx] = 2; m_data[idx] = wdata;
            end else begin
                push(0, 0, 0, 0, 1);
                m_st[idx] = 1; m_data[idx] = wdata;
            end
        end
        @(negedge clk);
        chk(req, "ready before request", cpu_ready, 1);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = DW'(wdata);
        bus_shared_in = sh; bus_rdata = DW'(rd);
        @(negedge clk);
        cpu_req = 1'b0;
        for (int k = 0; k < q_valid.size(); k++) begin
            if (k > 0) @(negedge clk);
            chk(req, "bus_valid", bus_valid, q_valid[k]);
            if (q_valid[k] != 0) begin
                chk(req, "bus_cmd", bus_cmd, q_cmd[k]);
                chk(req, "bus_addr", bus_addr, q_addr[k]);
                chk(req, "bus_data", bus_data, q_data[k]);
            end
            chk(req, "cpu_done", cpu_done, q_done[k]);
            if (q_done[k] != 0 && !we)
                chk(req, "cpu_rdata", cpu_rdata, m_data[idx]);
        end
        bus_shared_in = 1'b0;
    endtask

    // cmd: 0 read, 1 update, 2 flush. A processor request is offered meanwhile and must be ignored.
    task automatic snoop_op(input string req, input int cmd, input int addr, input int data);
        int idx = addr % NL;
        int tag = addr / NL;
        bit hit = (m_present[idx] != 0) && (m_tag[idx] == tag);
        bit sh  = hit && (cmd != 2);
        bit sup = sh && (cmd == 0) && (m_st[idx] == 1);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(addr); snp_data = DW'(data);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'hFF;
        #1;
        chk(req, "snp_shared", snp_shared, sh);
        chk(req, "snp_supply", snp_supply, sup);
        if (sup) chk(req, "snp_flush_data", snp_flush_data, m_data[idx]);
        chk("R11", "ready during snoop", cpu_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0; cpu_req = 1'b0;
        chk("R11", "no bus after ignored request", bus_valid, 0);
        chk("R11", "no done after ignored request", cpu_done, 0);
        if (sh) begin
            m_st[idx] = 2;
            if (cmd == 1) m_data[idx] = data;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            m_present[i] = 0; m_tag[i] = 0; m_st[i] = 0; m_data[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", cpu_ready, 1);
        chk("R1", "bus idle after reset", bus_valid, 0);
        chk("R1", "done low after reset", cpu_done, 0);

        cpu_op("R2", 0, 'h10, 0, 0, 'h1111);     // R1 R2: cold miss, exclusive fill
        cpu_op("R3", 0, 'h10, 0, 0, 0);          // R3: read hit
        cpu_op("R4", 1, 'h10, 'hA0A0, 0, 0);     // R4: exclusive -> dirty, quiet
        cpu_op("R4", 1, 'h10, 'hA1A1, 1, 0);     // R4: dirty stays dirty
        cpu_op("R3", 0, 'h10, 0, 0, 0);
        cpu_op("R2", 0, 'h21, 0, 1, 'h2222);     // R2: shared fill
        cpu_op("R5", 1, 'h21, 'h3333, 1, 0);     // R5: stays shared
        cpu_op("R5", 1, 'h21, 'h4444, 0, 0);     // R5: drops to exclusive
        cpu_op("R5", 1, 'h21, 'h5555, 0, 0);     // R5: proven exclusive (quiet write)
        snoop_op("R9", 0, 'h21, 0);              // R9: dirty supplies, -> shared
        cpu_op("R9", 1, 'h21, 'h6666, 1, 0);     // R9: update shows shared
        snoop_op("R10", 1, 'h21, 'hABCD);        // R10
        cpu_op("R10", 0, 'h21, 0, 0, 0);
        snoop_op("R8", 0, 'h25, 0);              // R8: tag miss
        snoop_op("R9", 0, 'h10, 0);              // R9: dirty line 0x10
        snoop_op("R8", 0, 'h10, 0);              // R8: shared, no supply
        cpu_op("R6", 1, 'h32, 'h7777, 0, 0);     // R6: private write miss -> dirty
        cpu_op("R6", 0, 'h32, 0, 0, 0);
        cpu_op("R6", 1, 'h33, 'h8888, 1, 0);     // R6: shared write miss -> update
        cpu_op("R7", 0, 'h36, 0, 0, 'h9999);     // R7: dirty victim flushed
        cpu_op("R7", 0, 'h37, 0, 0, 'hBBBB);     // R7: clean victim dropped
        cpu_op("R4", 1, 'h36, 'hCCCC, 0, 0);
        cpu_op("R7", 1, 'h3A, 'hDDDD, 1, 0);     // R7 R6: flush, read, update
        snoop_op("R8", 2, 'h3A, 0);              // R8: flush never asserts shared
        snoop_op("R10", 1, 'h37, 'hEEEE);        // R10: exclusive -> shared
        cpu_op("R10", 0, 'h37, 0, 0, 0);
        cpu_op("R10", 1, 'h37, 'h1234, 1, 0);    // R10: shared proven by update

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule